// File: doc/BRIEF.md
# Energy Accumulation Mode Conditioner

This block sits between the per-sample active and reactive power values and the energy registers and pulse generator of a metering datapath. Each valid sample carries a signed active power value and a signed reactive power value. A small mode field tells the block how to condition each of them before it is summed. Active power can be summed as it is, as its magnitude, or with negative samples dropped. Reactive power can be summed as it is, as its magnitude, or with its sign flipped whenever the active power of the same sample is negative.

The same conditioned values go to two places. They feed a pair of wrap-around energy accumulators that are built into the block. They also appear on a pulse-path output pair for a downstream frequency-to-pulse converter. All results are registered, so they show up one cycle after the valid strobe. When the mode field is all zero, the block performs plain signed accumulation.

Top module: `enacc_conditioner`

## Requirements
- R1: When mode bit 0 (active magnitude) is 1, the conditioned active value is the absolute value of the active sample. A sample equal to the most negative 24-bit value (-8388608) gives 8388607.
- R2: When mode bit 1 (active positive-only) is 1 and bit 0 is 0, a negative active sample gives a conditioned value of 0, and a non-negative sample passes unchanged. When bit 0 is also 1, magnitude mode wins.
- R3: When mode bit 2 (reactive follows active sign) is 1 and bit 3 is 0, the reactive sample passes unchanged if the active sample's sign bit is 0. If that sign bit is 1, the reactive sample is negated, and -8388608 saturates to 8388607.
- R4: When mode bit 3 (reactive magnitude) is 1, the conditioned reactive value is the absolute value of the reactive sample, with the same saturation. This takes priority over bit 2.
- R5: After reset, every output is 0: incrValid, both increments, both pulse values and both energies.
- R6: With mode bits 3:0 all 0, both conditioned values equal the input samples unchanged.
- R7: incrValid is 1 exactly in the cycle after a cycle with sampleValid high. actIncr and reactIncr take the conditioned values at that edge and hold them while no sample arrives.
- R8: pulseAct and pulseReact carry the conditioned values in the cycle after a valid sample, and are 0 in every other cycle.
- R9: actEnergy and reactEnergy (ACC_W bits, 48 by default) add the sign-extended conditioned value at each valid edge, wrap modulo 2^ACC_W, and hold when no sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe |
| modeCfg | input | 4 | Mode bits: 0 active magnitude, 1 active positive-only, 2 reactive follows active sign, 3 reactive magnitude |
| activeIn | input | 24 | Active power sample, two's complement |
| reactiveIn | input | 24 | Reactive power sample, two's complement |
| incrValid | output | 1 | Registered strobe for the increments |
| actIncr | output | 24 | Conditioned active increment |
| reactIncr | output | 24 | Conditioned reactive increment |
| pulseAct | output | 24 | Active value for the pulse path, 0 when idle |
| pulseReact | output | 24 | Reactive value for the pulse path, 0 when idle |
| actEnergy | output | ACC_W | Active energy accumulator |
| reactEnergy | output | ACC_W | Reactive energy accumulator |

## Verification
The reactive result depends on the active sample of the same cycle. Active conditioning (zeroing or magnitude) and reactive sign-following therefore both act on one sample. The sweep drives every mode against every pairing of signs and extreme values: both samples negative, both at the most negative code, zero, and the maximum. It checks both increments, and the pulse pair, against a bench model that decides the reactive flip from the raw active sign. A second instance with a narrow accumulator shows that the energies wrap.

// File: rtl/enacc_pkg.sv
`timescale 1ns/1ps
package enacc_pkg;
  // strobes passed from the control decode to the datapath
  typedef struct packed {
    logic load;        // accept the sample this cycle
    logic actNegate;   // take the saturated negation of the active sample
    logic actClear;    // force the active contribution to zero
    logic reactNegate; // take the saturated negation of the reactive sample
  } condCtrl_t;

  localparam int MODE_W      = 4;
  localparam int BIT_ACT_ABS = 0;
  localparam int BIT_ACT_POS = 1;
  localparam int BIT_RCT_FOL = 2;
  localparam int BIT_RCT_ABS = 3;
endpackage

// File: rtl/enacc_ctrl.sv
`timescale 1ns/1ps
module enacc_ctrl
  import enacc_pkg::*;
(
  input  logic              sampleValid,
  input  logic [MODE_W-1:0] modeCfg,
  input  logic              actSign,
  input  logic              reactSign,
  output condCtrl_t         ctrl
);
  logic actAbs, actPos, rctFol, rctAbs;

  always_comb begin
    actAbs = modeCfg[BIT_ACT_ABS];
    actPos = modeCfg[BIT_ACT_POS];
    rctFol = modeCfg[BIT_RCT_FOL];
    rctAbs = modeCfg[BIT_RCT_ABS];

    ctrl.load      = sampleValid;
    // magnitude wins over positive-only on the active side
    ctrl.actNegate = actAbs & actSign;
    ctrl.actClear  = ~actAbs & actPos & actSign;
    // magnitude wins over sign-following on the reactive side
    if (rctAbs)
      ctrl.reactNegate = reactSign;
    else
      ctrl.reactNegate = rctFol & actSign;
  end
endmodule

// File: rtl/enacc_dp.sv
`timescale 1ns/1ps
module enacc_dp
  import enacc_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  condCtrl_t         ctrl,
  input  logic [DATA_W-1:0] activeIn,
  input  logic [DATA_W-1:0] reactiveIn,
  output logic              incrValid,
  output logic [DATA_W-1:0] actIncr,
  output logic [DATA_W-1:0] reactIncr,
  output logic [DATA_W-1:0] pulseAct,
  output logic [DATA_W-1:0] pulseReact,
  output logic [ACC_W-1:0]  actEnergy,
  output logic [ACC_W-1:0]  reactEnergy
);
  localparam int EXT_W = ACC_W - DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic [DATA_W-1:0] satNeg(input logic [DATA_W-1:0] x);
    if (x == MOST_NEG) return MOST_POS;
    return ~x + 1'b1;
  endfunction

  logic [DATA_W-1:0] actCond, reactCond;
  logic [ACC_W-1:0]  actExt, reactExt;

  always_comb begin
    if (ctrl.actClear)
      actCond = '0;
    else if (ctrl.actNegate)
      actCond = satNeg(activeIn);
    else
      actCond = activeIn;
    reactCond = ctrl.reactNegate ? satNeg(reactiveIn) : reactiveIn;
    actExt    = {{EXT_W{actCond[DATA_W-1]}}, actCond};
    reactExt  = {{EXT_W{reactCond[DATA_W-1]}}, reactCond};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      incrValid   <= 1'b0;
      actIncr     <= '0;
      reactIncr   <= '0;
      pulseAct    <= '0;
      pulseReact  <= '0;
      actEnergy   <= '0;
      reactEnergy <= '0;
    end else begin
      incrValid <= ctrl.load;
      if (ctrl.load) begin
        actIncr     <= actCond;
        reactIncr   <= reactCond;
        pulseAct    <= actCond;
        pulseReact  <= reactCond;
        actEnergy   <= actEnergy + actExt;
        reactEnergy <= reactEnergy + reactExt;
      end else begin
        pulseAct   <= '0;
        pulseReact <= '0;
      end
    end
  end
endmodule

// File: rtl/enacc_conditioner.sv
`timescale 1ns/1ps
module enacc_conditioner
  import enacc_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [MODE_W-1:0] modeCfg,
  input  logic [DATA_W-1:0] activeIn,
  input  logic [DATA_W-1:0] reactiveIn,
  output logic              incrValid,
  output logic [DATA_W-1:0] actIncr,
  output logic [DATA_W-1:0] reactIncr,
  output logic [DATA_W-1:0] pulseAct,
  output logic [DATA_W-1:0] pulseReact,
  output logic [ACC_W-1:0]  actEnergy,
  output logic [ACC_W-1:0]  reactEnergy
);
  condCtrl_t ctrl;

  enacc_ctrl ctrl_i (
    .sampleValid (sampleValid),
    .modeCfg     (modeCfg),
    .actSign     (activeIn[DATA_W-1]),
    .reactSign   (reactiveIn[DATA_W-1]),
    .ctrl        (ctrl)
  );

  enacc_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .activeIn    (activeIn),
    .reactiveIn  (reactiveIn),
    .incrValid   (incrValid),
    .actIncr     (actIncr),
    .reactIncr   (reactIncr),
    .pulseAct    (pulseAct),
    .pulseReact  (pulseReact),
    .actEnergy   (actEnergy),
    .reactEnergy (reactEnergy)
  );
endmodule

// File: rtl/enacc_conditioner_chk.sv
`timescale 1ns/1ps
module enacc_conditioner_chk
  import enacc_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [MODE_W-1:0] modeCfg,
  input logic [DATA_W-1:0] activeIn,
  input logic [DATA_W-1:0] reactiveIn,
  input logic              incrValid,
  input logic [DATA_W-1:0] actIncr,
  input logic [DATA_W-1:0] reactIncr,
  input logic [DATA_W-1:0] pulseAct,
  input logic [DATA_W-1:0] pulseReact,
  input logic [ACC_W-1:0]  actEnergy,
  input logic [ACC_W-1:0]  reactEnergy
);
  AST_ACT_MAG_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && modeCfg[0] |=> !actIncr[DATA_W-1]); // R1
  AST_ACT_POS_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && modeCfg[1] |=> !actIncr[DATA_W-1]); // R2
  AST_RCT_MAG_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && modeCfg[3] |=> !reactIncr[DATA_W-1]); // R4
  AST_RCT_FOLLOW_POS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && modeCfg[3:2] == 2'b01 && !activeIn[DATA_W-1]
    |=> reactIncr == $past(reactiveIn)); // R3
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && modeCfg == '0
    |=> actIncr == $past(activeIn) && reactIncr == $past(reactiveIn)); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> incrValid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !incrValid && $stable(actIncr) && $stable(reactIncr)); // R7
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !incrValid |-> pulseAct == '0 && pulseReact == '0); // R8
  AST_ENERGY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(actEnergy) && $stable(reactEnergy)); // R9
endmodule

bind enacc_conditioner enacc_conditioner_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .modeCfg(modeCfg),
  .activeIn(activeIn), .reactiveIn(reactiveIn), .incrValid(incrValid),
  .actIncr(actIncr), .reactIncr(reactIncr), .pulseAct(pulseAct),
  .pulseReact(pulseReact), .actEnergy(actEnergy), .reactEnergy(reactEnergy)
);

// File: tb/enacc_conditioner_tb_top.sv
`timescale 1ns/1ps
module enacc_conditioner_tb_top;
  localparam int DW  = 24;
  localparam int AW  = 48;
  localparam int AWN = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [3:0] modeCfg = '0;
  logic signed [DW-1:0] activeIn = '0, reactiveIn = '0;

  logic incrValid, incrValidN;
  logic signed [DW-1:0] actIncr, reactIncr, pulseAct, pulseReact;
  logic signed [DW-1:0] actIncrN, reactIncrN, pulseActN, pulseReactN;
  logic [AW-1:0]  actEnergy, reactEnergy;
  logic [AWN-1:0] actEnergyN, reactEnergyN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0]  expA = '0, expR = '0;
  logic [AWN-1:0] expAn = '0, expRn = '0;
  int lastA = 0, lastR = 0;

  always #2 clk = ~clk;

  enacc_conditioner #(.DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .modeCfg(modeCfg),
    .activeIn(activeIn), .reactiveIn(reactiveIn), .incrValid(incrValid),
    .actIncr(actIncr), .reactIncr(reactIncr), .pulseAct(pulseAct),
    .pulseReact(pulseReact), .actEnergy(actEnergy), .reactEnergy(reactEnergy));

  enacc_conditioner #(.DATA_W(DW), .ACC_W(AWN)) dut_w (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .modeCfg(modeCfg),
    .activeIn(activeIn), .reactiveIn(reactiveIn), .incrValid(incrValidN),
    .actIncr(actIncrN), .reactIncr(reactIncrN), .pulseAct(pulseActN),
    .pulseReact(pulseReactN), .actEnergy(actEnergyN), .reactEnergy(reactEnergyN));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int negSat(input int v);
    return (v == -8388608) ? 8388607 : -v;
  endfunction

  function automatic int modelAct(input int a, input logic [3:0] m);
    if (m[0]) return (a < 0) ? negSat(a) : a;
    if (m[1] && a < 0) return 0;
    return a;
  endfunction

  function automatic int modelReact(input int a, input int r, input logic [3:0] m);
    if (m[3]) return (r < 0) ? negSat(r) : r;
    if (m[2] && a < 0) return negSat(r);
    return r;
  endfunction

  task automatic sample(input int a, input int r, input logic [3:0] m);
    string ta, tr;
    int ea, er;
    @(negedge clk);
    sampleValid = 1'b1; modeCfg = m;
    activeIn = DW'(a); reactiveIn = DW'(r);
    ea = modelAct(a, m);
    er = modelReact(a, r, m);
    ta = m[0] ? "R1" : (m[1] ? "R2" : "R6");
    tr = m[3] ? "R4" : (m[2] ? "R3" : "R6");
    expA  = expA  + AW'(longint'(ea));
    expR  = expR  + AW'(longint'(er));
    expAn = expAn + AWN'(longint'(ea));
    expRn = expRn + AWN'(longint'(er));
    lastA = ea; lastR = er;
    @(posedge clk); #1;
    sampleValid = 1'b0;
    chk(ta, longint'(actIncr), longint'(ea));
    chk(tr, longint'(reactIncr), longint'(er));
    chk("R7", longint'(incrValid), 1);
    chk("R8", longint'(pulseAct), longint'(ea));
    chk("R8", longint'(pulseReact), longint'(er));
    chk("R9", longint'(actEnergy), longint'(expA));
    chk("R9", longint'(reactEnergy), longint'(expR));
    chk("R9", longint'(actEnergyN), longint'(expAn));
    chk("R9", longint'(reactEnergyN), longint'(expRn));
  endtask

  task automatic idle(input int a, input int r);
    @(negedge clk);
    sampleValid = 1'b0; activeIn = DW'(a); reactiveIn = DW'(r);
    @(posedge clk); #1;
    chk("R7", longint'(incrValid), 0);
    chk("R7", longint'(actIncr), longint'(lastA));
    chk("R7", longint'(reactIncr), longint'(lastR));
    chk("R8", longint'(pulseAct), 0);
    chk("R8", longint'(pulseReact), 0);
    chk("R9", longint'(actEnergy), longint'(expA));
    chk("R9", longint'(reactEnergyN), longint'(expRn));
  endtask

  initial begin
    int vals[7] = '{0, 1, -1, 8388607, -8388608, 12345, -54321};
    repeat (3) @(posedge clk);
    #1;
    // R5: reset state of both instances
    chk("R5", longint'(incrValid), 0);
    chk("R5", longint'(actIncr), 0);
    chk("R5", longint'(reactIncr), 0);
    chk("R5", longint'(pulseAct), 0);
    chk("R5", longint'(pulseReact), 0);
    chk("R5", longint'(actEnergy), 0);
    chk("R5", longint'(reactEnergy), 0);
    chk("R5", longint'(actEnergyN), 0);
    @(negedge clk) rstN = 1'b1;

    // sweep every mode against every pair of sample values
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 7; j++) begin
          sample(vals[i], vals[j], 4'(m));
        end
      end
      idle(-5, 7);
    end

    // R9: drive the narrow accumulators through several wraps
    for (int k = 0; k < 10; k++) sample(8388607, -8388608, 4'd0);
    idle(0, 0);
    for (int k = 0; k < 10; k++) sample(-8388608, 8388607, 4'd0);
    idle(0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule